// File: doc/BRIEF.md
# Counter-Addressed Pattern Sequencer

This block plays a fixed pattern of four control signals over and over. A small binary address counter steps through a read-only table of five 4-bit words, moving to the next word on every rising clock edge. The word at the current address drives the control outputs. When the counter is on its last entry, a decode of that terminal address blocks the increment and forces a synchronous clear. The pattern therefore repeats every five cycles, and no out-of-range address ever reaches the outputs.

A push button input, active high while pressed, holds the counter at address 0. While the button is held, counting is blocked. The same combined term that enables counting also releases the clear, and that term is false whenever the button is pressed or the terminal address is present. The button passes through a two-stage synchronizer before it is used. The table contents are a parameter, so the pattern is fixed when the design is built.

Top module: `wseq_top`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the address and both synchronizer stages clear. After reset the address is 0 and `ctrl_o` equals table entry 0.
- R2: `ctrl_o` equals the table entry selected by `addr_o`. Entry n is `PATTERN[4n+3:4n]`, and the default `PATTERN` is 20'hF8421 (entries 1, 2, 4, 8, F).
- R3: While the synchronized button level is low and the address is below 4, each rising edge raises the address by exactly one.
- R4: While the button is released and the address is 4, the next edge returns the address to 0. The address never exceeds 4, and the output sequence has a period of exactly five cycles.
- R5: If `btn_i` is high at edge k, the address is 0 after edge k+2. It stays 0 after every later edge until the release takes effect. A one-cycle press is enough to clear it.
- R6: If `btn_i` is first sampled low at edge j after a press, the address is still 0 after edge j+1 and is 1 after edge j+2.
- R7: `ctrl_o` changes only as a result of a clock edge, and it holds one value for the whole cycle between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_i | input | 1 | Clear button, high while pressed, asynchronous to `clk` |
| ctrl_o | output | 4 | Control word read from the table |
| addr_o | output | 3 | Current table address |

## Verification
The hardest cases to reach are a press that arrives at each of the five phases of the period, and in particular one that lands on the terminal address. In that case the button clear and the wrap clear are both active at the same edge. Presses of one to four cycles, including single-cycle pulses, are therefore started at every phase, and the bench tracks the two-stage synchronizer delay. The bench also checks the exact release edge and the mid-cycle stability of the output.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  localparam int unsigned WORD_W    = 4;
  localparam int unsigned ENTRIES   = 5;
  localparam logic [ENTRIES*WORD_W-1:0] DEF_PATTERN = 20'hF8421;

  typedef enum logic [1:0] {
    STEP_ADVANCE = 2'd0,
    STEP_WRAP    = 2'd1,
    STEP_HOLD    = 2'd2
  } step_e;
endpackage

// File: rtl/wseq_sync.sv
module wseq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/wseq_addr_ctr.sv
module wseq_addr_ctr
  import wseq_pkg::*;
#(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_i,
  output logic [CNT_W-1:0] addr_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);

  logic [CNT_W-1:0] addr_q;
  logic             at_last;
  logic             run_ok;
  step_e            step;

  assign at_last = (addr_q == LAST);
  // one combined term: true enables counting, false forces the clear
  assign run_ok  = ~(hold_i | at_last);

  always_comb begin
    if (hold_i)      step = STEP_HOLD;
    else if (!run_ok) step = STEP_WRAP;
    else             step = STEP_ADVANCE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else begin
      case (step)
        STEP_ADVANCE: addr_q <= addr_q + 1'b1;
        default:      addr_q <= '0;
      endcase
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/wseq_rom.sv
module wseq_rom #(
  parameter int unsigned DEPTH  = 5,
  parameter int unsigned WORD_W = 4,
  parameter int unsigned CNT_W  = 3,
  parameter logic [DEPTH*WORD_W-1:0] PATTERN = '0
) (
  input  logic [CNT_W-1:0]  addr_i,
  output logic [WORD_W-1:0] data_o
);
  logic [WORD_W-1:0] mem [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
      assign mem[g] = PATTERN[g*WORD_W +: WORD_W];
    end
  endgenerate

  always_comb begin
    data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (addr_i == CNT_W'(i)) data_o = mem[i];
    end
  end
endmodule

// File: rtl/wseq_top.sv
module wseq_top
  import wseq_pkg::*;
#(
  parameter int unsigned DEPTH       = ENTRIES,
  parameter int unsigned DATA_W      = WORD_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DEPTH*DATA_W-1:0] PATTERN = DEF_PATTERN,
  localparam int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              btn_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  addr_o
);
  logic btn_s;

  wseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (btn_i),
    .q_o (btn_s)
  );

  wseq_addr_ctr #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .hold_i (btn_s),
    .addr_o (addr_o)
  );

  wseq_rom #(
    .DEPTH(DEPTH), .WORD_W(DATA_W), .CNT_W(CNT_W), .PATTERN(PATTERN)
  ) u_rom (
    .addr_i (addr_o),
    .data_o (ctrl_o)
  );
endmodule

// File: rtl/wseq_chk.sv
module wseq_chk #(
  parameter int unsigned DEPTH  = 5,
  parameter int unsigned DATA_W = 4,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              btn_i,
  input logic [DATA_W-1:0] ctrl_i,
  input logic [CNT_W-1:0]  addr_i
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);

  logic p1, p2;
  always_ff @(posedge clk) begin
    if (rst) begin
      p1 <= 1'b0;
      p2 <= 1'b0;
    end else begin
      p1 <= btn_i;
      p2 <= p1;
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> addr_i == '0); // R1
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst) addr_i <= LAST); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!p2 && addr_i != LAST) |=> addr_i == $past(addr_i) + 1'b1); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!p2 && addr_i == LAST) |=> addr_i == '0); // R4
  AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    p2 |=> addr_i == '0); // R5
  AST_RELEASE_RESUME: assert property (@(posedge clk) disable iff (rst)
    (p2 && !p1) |=> ##1 addr_i == CNT_W'(1)); // R6
  AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (rst)
    $stable(addr_i) |-> $stable(ctrl_i)); // R7
endmodule

bind wseq_top wseq_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .btn_i  (btn_i),
  .ctrl_i (ctrl_o),
  .addr_i (addr_o)
);

// File: tb/wseq_top_test.sv
`timescale 1ns/1ps
module wseq_top_test;
  localparam logic [19:0] PAT = 20'hF8421;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       btn = 1'b0;
  logic [3:0] ctrl;
  logic [2:0] addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench-side model of the requirements
  int  exp_addr = 0;
  bit  m1 = 0, m2 = 0;

  wseq_top #(.PATTERN(PAT)) uut (
    .clk(clk), .rst(rst), .btn_i(btn), .ctrl_o(ctrl), .addr_o(addr)
  );

  always #2.5 clk = ~clk;

  function automatic logic [3:0] entry(int n);
    return 4'((PAT >> (4 * n)) & 20'hF);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input bit r, input bit b);
    string tag;
    bit was_hold, was_rel, was_last;
    @(posedge clk);
    was_hold = m2;
    was_rel  = m2 && !m1;
    was_last = (exp_addr == 4);
    if (rst) begin
      exp_addr = 0; m1 = 0; m2 = 0;
      tag = "R1";
    end else begin
      exp_addr = m2 ? 0 : (exp_addr == 4 ? 0 : exp_addr + 1);
      m2 = m1; m1 = btn;
      if (was_rel) tag = "R6";
      else if (was_hold) tag = "R5";
      else if (was_last) tag = "R4";
      else tag = "R3";
    end
    #1;
    chk(tag, int'(addr), exp_addr);
    chk("R2", int'(ctrl), int'(entry(exp_addr)));
    rst = r;
    btn = b;
    #2;
    chk("R7", int'(ctrl), int'(entry(exp_addr)));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tick(1, 0); tick(1, 0); tick(0, 0);
    chk("R1", int'(addr), 0);
    chk("R1", int'(ctrl), int'(entry(0)));
    // R3 R4 R2: free run, several periods
    for (int i = 0; i < 17; i++) tick(0, 0);
    // R5 R6: press at every phase with lengths 1..4
    for (int ph = 0; ph < 5; ph++) begin
      for (int len = 1; len <= 4; len++) begin
        while (exp_addr != ph) tick(0, 0);
        for (int k = 0; k < len; k++) tick(0, 1);
        for (int k = 0; k < 8; k++) tick(0, 0);
      end
    end
    // long press then release
    for (int k = 0; k < 12; k++) tick(0, 1);
    for (int k = 0; k < 12; k++) tick(0, 0);
    // R1: reset in mid-run while pressed
    tick(0, 0); tick(1, 1); tick(0, 0);
    for (int k = 0; k < 8; k++) tick(0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule